// File: doc/BRIEF.md
# Address-Folded SECDED Codec

This block is a purely combinational encoder and decoder for a single-error-correcting, double-error-detecting Hamming code. The code covers a 128-bit data word and the 18 word-address bits (address bits 21 down to 4) of the location that holds it. That gives 146 protected bits and 9 check bits, which makes a 155-bit codeword with minimum distance 4. The address bits are never stored. They are folded into the check bits on a write and supplied again on a read. A read that lands on the wrong word therefore shows up as a fault in the address field, not as silent data.

The encoder side turns a data word and its address into check bits, which are stored next to the data. The decoder side takes the data read back, the address of the request and the stored check bits. It recomputes the check bits and compares the two sets. It then reports one of five outcomes: clean, a single error in the data (the bit is corrected), a single error in the address, a single error in the check bits, or an uncorrectable error. For each single error it also gives the bit index within the field where the error fell. Memory access, error logging and configuration are left to the surrounding logic.

Top module: `secded_addr_codec`

## Requirements
- R1: The protected bits are numbered with data bit j as protected index j and address bit m (m=0 is word-address bit 4) as protected index 128+m. Protected index k is placed at the (k+1)-th Hamming position, counting upward from 3, that is not a power of two. Check bit i (i=0..7) is the XOR of every protected bit whose position has bit i set.
- R2: Check bit 8 makes the whole 155-bit codeword, meaning all protected bits and all nine check bits, have even parity.
- R3: When the read data, the address and the stored check bits form a valid codeword, the decoder reports class 0 (none), uncorrectable 0 and index 0, and passes the data through unchanged.
- R4: A single flipped data bit j gives class 1 (data) and index j. The corrected-data output equals the data as originally written.
- R5: A single flipped address bit m (request address differs from write address in bit m) gives class 2 (address) and index m. The data is passed through unchanged.
- R6: A single flipped stored check bit i (0..8, with 8 being the overall parity bit) gives class 3 (check) and index i. The data is passed through unchanged.
- R7: Any two flipped bits anywhere in the 155-bit codeword give uncorrectable 1, class 0 and index 0, and the data is passed through unchanged.
- R8: The outputs respond to the inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data | input | 128 | Data word being written |
| enc_addr | input | 18 | Word address (bits 21..4) of the write |
| enc_chk | output | 9 | Check bits to store; bit 8 is overall parity |
| dec_data | input | 128 | Data word read from storage |
| dec_addr | input | 18 | Word address (bits 21..4) of the read request |
| dec_chk | input | 9 | Check bits read from storage |
| dec_data_fix | output | 128 | Read data with a single data-bit error corrected |
| dec_class | output | 2 | 0 none, 1 data, 2 address, 3 check-bit error |
| dec_index | output | 8 | Bit index of a single error within its field |
| dec_uncorr | output | 1 | Uncorrectable (double) error detected |

## Verification
The encoder is checked against a separately written model on all-zero and all-one words and on random words and addresses. Every one of the 155 single-bit flips is injected on several random codewords. This shows that the three fields are told apart and that each index is exact, including the overall parity bit and the power-of-two check positions. Random pairs of flips, together with directed pairs, confirm that a double error is never mistaken for a correctable one. The directed pairs are: two data bits, one address bit with one check bit, and the overall parity bit with a position check bit.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_DATA  = 2'd1,
    ERR_ADDR  = 2'd2,
    ERR_CHECK = 2'd3
  } err_class_e;

  // Number of position checks needed for prot_w protected bits.
  function automatic int pos_bits(input int prot_w);
    int r;
    r = 1;
    while ((1 << r) < prot_w + r + 1) r++;
    return r;
  endfunction

  // Hamming position of protected bit k: (k+1)-th non-power-of-two from 3.
  function automatic int prot_pos(input int k);
    int p;
    int n;
    p = 2;
    n = -1;
    while (n < k) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) if ((v >> i) > 1) r = i + 1;
    return r;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Inverse of prot_pos for a non-power-of-two position p.
  function automatic int pos_to_prot(input int p);
    return p - 2 - floor_log2(p);
  endfunction

endpackage

// File: rtl/secded_check_gen.sv
module secded_check_gen
  import secded_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  localparam int PROT_W = DATA_W + ADDR_W,
  localparam int POS_W  = pos_bits(PROT_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [POS_W-1:0]  pos_chk,
  output logic              prot_par
);

  logic [PROT_W-1:0] prot;
  logic [POS_W-1:0]  contrib [PROT_W];

  assign prot = {addr, data};

  generate
    for (genvar k = 0; k < PROT_W; k++) begin : g_bit
      localparam logic [POS_W-1:0] POS = POS_W'(prot_pos(k));
      assign contrib[k] = prot[k] ? POS : '0;
    end
  endgenerate

  always_comb begin
    pos_chk = '0;
    for (int k = 0; k < PROT_W; k++) pos_chk = pos_chk ^ contrib[k];
  end

  assign prot_par = ^prot;

endmodule

// File: rtl/secded_locate.sv
module secded_locate
  import secded_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  localparam int PROT_W = DATA_W + ADDR_W,
  localparam int POS_W  = pos_bits(PROT_W)
) (
  input  logic [POS_W-1:0] syndrome,
  input  logic             parity_fault,
  output err_class_e       err_class,
  output logic [POS_W-1:0] err_index,
  output logic             uncorr
);

  localparam int LAST_POS = PROT_W + POS_W;

  int syn_i;
  int k_i;

  always_comb begin
    syn_i     = int'(syndrome);
    k_i       = pos_to_prot(syn_i);
    err_class = ERR_NONE;
    err_index = '0;
    uncorr    = 1'b0;
    if (!parity_fault) begin
      if (syn_i != 0) uncorr = 1'b1;
    end else if (syn_i == 0) begin
      err_class = ERR_CHECK;
      err_index = POS_W'(POS_W);
    end else if (is_pow2(syn_i)) begin
      err_class = ERR_CHECK;
      err_index = POS_W'(floor_log2(syn_i));
    end else if (syn_i > LAST_POS) begin
      uncorr = 1'b1;
    end else if (k_i < DATA_W) begin
      err_class = ERR_DATA;
      err_index = POS_W'(k_i);
    end else begin
      err_class = ERR_ADDR;
      err_index = POS_W'(k_i - DATA_W);
    end
  end

endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  err_class_e        err_class,
  input  logic [IDX_W-1:0]  err_index,
  output logic [DATA_W-1:0] data_out
);

  generate
    for (genvar j = 0; j < DATA_W; j++) begin : g_flip
      assign data_out[j] = data_in[j] ^
                           ((err_class == ERR_DATA) && (err_index == IDX_W'(j)));
    end
  endgenerate

endmodule

// File: rtl/secded_addr_codec.sv
module secded_addr_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  localparam int PROT_W = DATA_W + ADDR_W,
  localparam int POS_W  = pos_bits(PROT_W),
  localparam int CHK_W  = POS_W + 1
) (
  input  logic [DATA_W-1:0] enc_data,
  input  logic [ADDR_W-1:0] enc_addr,
  output logic [CHK_W-1:0]  enc_chk,
  input  logic [DATA_W-1:0] dec_data,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [CHK_W-1:0]  dec_chk,
  output logic [DATA_W-1:0] dec_data_fix,
  output logic [1:0]        dec_class,
  output logic [POS_W-1:0]  dec_index,
  output logic              dec_uncorr
);

  logic [POS_W-1:0] enc_pos;
  logic             enc_par;
  logic [POS_W-1:0] calc_pos;
  logic             calc_par;
  logic [CHK_W-1:0] dec_chk_calc;
  logic [POS_W-1:0] syndrome;
  logic             parity_fault;
  err_class_e       cls;

  secded_check_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_enc_gen (
    .data(enc_data), .addr(enc_addr), .pos_chk(enc_pos), .prot_par(enc_par)
  );

  assign enc_chk = {enc_par ^ (^enc_pos), enc_pos};

  secded_check_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_gen (
    .data(dec_data), .addr(dec_addr), .pos_chk(calc_pos), .prot_par(calc_par)
  );

  assign dec_chk_calc = {calc_par ^ (^calc_pos), calc_pos};
  assign syndrome     = calc_pos ^ dec_chk[POS_W-1:0];
  assign parity_fault = calc_par ^ (^dec_chk);

  secded_locate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_locate (
    .syndrome(syndrome), .parity_fault(parity_fault),
    .err_class(cls), .err_index(dec_index), .uncorr(dec_uncorr)
  );

  secded_fix #(.DATA_W(DATA_W), .IDX_W(POS_W)) u_fix (
    .data_in(dec_data), .err_class(cls), .err_index(dec_index),
    .data_out(dec_data_fix)
  );

  assign dec_class = cls;

endmodule

// File: rtl/secded_addr_codec_chk.sv
module secded_addr_codec_chk #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  parameter int POS_W  = 8,
  parameter int CHK_W  = 9
) (
  input logic [DATA_W-1:0] enc_data,
  input logic [ADDR_W-1:0] enc_addr,
  input logic [CHK_W-1:0]  enc_chk,
  input logic [DATA_W-1:0] dec_data,
  input logic [CHK_W-1:0]  dec_chk,
  input logic [CHK_W-1:0]  dec_chk_calc,
  input logic [DATA_W-1:0] dec_data_fix,
  input logic [1:0]        dec_class,
  input logic [POS_W-1:0]  dec_index,
  input logic              dec_uncorr
);

  always_comb begin
    if (!$isunknown({enc_data, enc_addr, enc_chk})) begin
      a_r2_enc_even_parity: assert (^{enc_data, enc_addr, enc_chk} == 1'b0);
    end
    if (!$isunknown({dec_data, dec_chk, dec_data_fix, dec_class, dec_index, dec_uncorr})) begin
      a_r7_double_quiet: assert (!dec_uncorr ||
        (dec_class == 2'd0 && dec_index == '0 && dec_data_fix == dec_data));
      a_r4_single_fix_one_bit: assert (dec_class != 2'd1 ||
        ($countones(dec_data_fix ^ dec_data) == 1 &&
         dec_data_fix[dec_index] != dec_data[dec_index]));
      a_r5_r6_data_kept: assert (dec_class < 2'd2 || dec_data_fix == dec_data);
      a_r3_clean_match: assert (dec_class != 2'd0 || dec_uncorr ||
        (dec_chk_calc == dec_chk && dec_data_fix == dec_data));
      a_r6_check_index_range: assert (dec_class != 2'd3 || dec_index <= POS_W);
    end
  end

endmodule

bind secded_addr_codec secded_addr_codec_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POS_W(POS_W), .CHK_W(CHK_W)
) u_chk (
  .enc_data(enc_data), .enc_addr(enc_addr), .enc_chk(enc_chk),
  .dec_data(dec_data), .dec_chk(dec_chk), .dec_chk_calc(dec_chk_calc),
  .dec_data_fix(dec_data_fix), .dec_class(dec_class),
  .dec_index(dec_index), .dec_uncorr(dec_uncorr)
);

// File: tb/secded_addr_codec_bench.sv
module secded_addr_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;
  localparam int AW = 18;
  localparam int CW = 9;
  localparam int NBITS = DW + AW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [DW-1:0] enc_data, dec_data, dec_data_fix;
  logic [AW-1:0] enc_addr, dec_addr;
  logic [CW-1:0] enc_chk, dec_chk;
  logic [1:0]    dec_class;
  logic [7:0]    dec_index;
  logic          dec_uncorr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  secded_addr_codec u_secded_addr_codec (
    .enc_data(enc_data), .enc_addr(enc_addr), .enc_chk(enc_chk),
    .dec_data(dec_data), .dec_addr(dec_addr), .dec_chk(dec_chk),
    .dec_data_fix(dec_data_fix), .dec_class(dec_class),
    .dec_index(dec_index), .dec_uncorr(dec_uncorr)
  );

  // Model: lay bits out as a position array, then compute parity groups.
  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d, input logic [AW-1:0] a);
    logic [DW+AW-1:0] pr;
    logic [255:0]     cw;
    logic [7:0]       c;
    int               k;
    pr = {a, d};
    cw = '0;
    c  = '0;
    k  = 0;
    for (int p = 1; p < DW + AW + 9; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = pr[k];
        k++;
      end
    end
    for (int i = 0; i < 8; i++)
      for (int p = 1; p < 256; p++)
        if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    return {(^pr) ^ (^c), c};
  endfunction

  task automatic report(input string req, input bit ok, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_enc(input logic [DW-1:0] d, input logic [AW-1:0] a);
    logic [CW-1:0] exp;
    @(posedge clk);
    enc_data = d;
    enc_addr = a;
    @(negedge clk);
    exp = ref_enc(d, a);
    report("R1", enc_chk[7:0] == exp[7:0], "position checks", DW'(enc_chk[7:0]), DW'(exp[7:0]));
    report("R2", enc_chk[8] == exp[8], "overall parity", DW'(enc_chk[8]), DW'(exp[8]));
  endtask

  // Apply a flip mask on {chk, addr, data} of a freshly encoded word.
  task automatic check_dec(input string req, input logic [DW-1:0] d, input logic [AW-1:0] a,
                           input logic [NBITS-1:0] flip, input logic [1:0] exp_cls,
                           input logic [7:0] exp_idx, input bit exp_unc);
    logic [NBITS-1:0] word;
    bit ok;
    word = {ref_enc(d, a), a, d} ^ flip;
    @(posedge clk);
    dec_data = word[DW-1:0];
    dec_addr = word[DW+AW-1:DW];
    dec_chk  = word[NBITS-1:DW+AW];
    @(negedge clk);
    ok = (dec_class == exp_cls) && (dec_index == exp_idx) && (dec_uncorr == exp_unc);
    report(req, ok, "class/index/uncorr", DW'({dec_class, dec_index, dec_uncorr}),
           DW'({exp_cls, exp_idx, exp_unc}));
    if (exp_cls == 2'd1) report(req, dec_data_fix == d, "corrected data", dec_data_fix, d);
    else report(req, dec_data_fix == word[DW-1:0], "data passthrough", dec_data_fix, word[DW-1:0]);
  endtask

  task automatic single_sweep(input logic [DW-1:0] d, input logic [AW-1:0] a);
    for (int f = 0; f < NBITS; f++) begin
      if (f < DW) check_dec("R4", d, a, NBITS'(1) << f, 2'd1, 8'(f), 1'b0);
      else if (f < DW + AW) check_dec("R5", d, a, NBITS'(1) << f, 2'd2, 8'(f - DW), 1'b0);
      else check_dec("R6", d, a, NBITS'(1) << f, 2'd3, 8'(f - DW - AW), 1'b0);
    end
  endtask

  task automatic double_flip(input logic [DW-1:0] d, input logic [AW-1:0] a, input int f1, input int f2);
    check_dec("R7", d, a, (NBITS'(1) << f1) | (NBITS'(1) << f2), 2'd0, 8'd0, 1'b1);
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    void'($urandom(32'h0005_EED5));
    enc_data = '0; enc_addr = '0;
    dec_data = '0; dec_addr = '0; dec_chk = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle all-zero inputs give a clean, zero result immediately
    report("R8", enc_chk == '0, "zero word check bits", DW'(enc_chk), '0);
    report("R3", dec_class == 2'd0 && !dec_uncorr && dec_data_fix == '0,
           "zero word clean", DW'({dec_class, dec_uncorr}), '0);

    check_enc('1, '1);
    for (int n = 0; n < 30; n++) check_enc(rnd_data(), AW'($urandom()));

    // R3 clean decodes
    check_dec("R3", '1, '1, '0, 2'd0, 8'd0, 1'b0);
    for (int n = 0; n < 10; n++) check_dec("R3", rnd_data(), AW'($urandom()), '0, 2'd0, 8'd0, 1'b0);

    // Every single flip on corner and random words
    single_sweep('0, '0);
    single_sweep('1, '1);
    for (int n = 0; n < 4; n++) single_sweep(rnd_data(), AW'($urandom()));

    // Directed double flips
    d = rnd_data();
    a = AW'($urandom());
    double_flip(d, a, 0, 1);
    double_flip(d, a, DW, DW + AW);
    double_flip(d, a, NBITS - 1, NBITS - 2);
    double_flip(d, a, NBITS - 1, 5);
    double_flip(d, a, DW - 1, DW);
    // Random double flips
    for (int n = 0; n < 300; n++) begin
      int f1, f2;
      f1 = int'($urandom() % NBITS);
      f2 = int'($urandom() % (NBITS - 1));
      if (f2 >= f1) f2++;
      double_flip(rnd_data(), AW'($urandom()), f1, f2);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule